// File: doc/BRIEF.md
# Multi-Format Serial Line Coder

This block turns a plain serial bit stream into one of four line codes: level, transition-on-one, return-to-zero and Manchester. The select input picks the code. A single clock runs at twice the bit rate, and an internal half-bit phase register splits every bit time into a first half and a second half. The codes that change level in the middle of a bit use that split.

The block paces its source through a bit strobe. The strobe is high for one clock cycle in every two. The rising clock edge that ends a strobe-high cycle takes the data bit and the format select, and that edge begins the next bit time. The coded output is a register, so the line is free of glitches. Reset asserts asynchronously and is released in step with the clock.

Top module: `serial_line_coder`

## Requirements
- R1: While rst_n is low, line_out and bit_strobe are 0, and they go to 0 as soon as rst_n falls, without waiting for a clock edge. After release the coder behaves as if a 0 bit in level format were in progress.
- R2: bit_strobe alternates 1, 0, 1, 0 on every clock after reset release. The rising edge that ends a strobe-high cycle samples din and fmt_sel and starts a bit, whose first half is the following cycle and whose second half is the cycle after that.
- R3: Format 2'b00 (level): line_out equals the sampled bit in both halves of the bit.
- R4: Format 2'b01 (transition-on-one): a running level inverts at the start of every bit whose value is 1 and keeps its value for a 0. The level is 0 after reset, and line_out shows the level in both halves.
- R5: Format 2'b10 (return-to-zero): line_out equals the sampled bit in the first half and is 0 in the second half.
- R6: Format 2'b11 (Manchester): a 1 bit is sent as 1 then 0, and a 0 bit as 0 then 1.
- R7: din and fmt_sel are sampled only at the start of a bit. Changing either input during the bit has no effect on line_out before the next bit starts.
- R8: The running level of R4 is updated on every bit whatever the selected format. After a switch to format 2'b01, the output continues from the parity of all bits sent since reset.
- R9: line_out is registered. It changes only at rising clock edges and shows the first half of a bit in the cycle right after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Coding clock, twice the bit rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| din | input | 1 | Serial data bit, sampled at the start of each bit |
| fmt_sel | input | 2 | Line code: 00 level, 01 transition-on-one, 10 return-to-zero, 11 Manchester |
| line_out | output | 1 | Coded serial line |
| bit_strobe | output | 1 | High in the cycle whose closing edge takes the next bit |

## Verification
The hardest case to reach from the ports is the transition-on-one output after a long run in other formats. Its level is hidden parity that never shows while another code is selected. The stimulus first sweeps every 4-bit pattern in each format. It then switches formats on every bit over a long mixed run, so the hidden level can be read out at arbitrary points. A reset in the middle of a bit is followed at once by a transition-on-one 1 bit, which shows that the level restarted at 0. Each bit also has its inputs inverted during its own time, to show they are ignored.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int FMT_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_LEVEL = 2'b00,
    FMT_XOR1  = 2'b01,
    FMT_RTZ   = 2'b10,
    FMT_MANCH = 2'b11
  } line_fmt_e;
endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/lc_phase_gen.sv
module lc_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic phase_q,
  output logic phase_d,
  output logic bit_start
);
  // phase 0 = first half of a bit, phase 1 = second half
  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  // the edge that closes a second half opens a new bit
  assign bit_start = phase_q;
endmodule

// File: rtl/lc_bit_store.sv
module lc_bit_store
  import lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take_en,
  input  logic      din,
  input  line_fmt_e fmt_in,
  output logic      bit_q,
  output logic      bit_d,
  output logic      lvl_q,
  output logic      lvl_d,
  output line_fmt_e fmt_q,
  output line_fmt_e fmt_d
);
  always_comb begin
    bit_d = bit_q;
    lvl_d = lvl_q;
    fmt_d = fmt_q;
    if (take_en) begin
      bit_d = din;
      lvl_d = lvl_q ^ din;
      fmt_d = fmt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      lvl_q <= 1'b0;
      fmt_q <= FMT_LEVEL;
    end else if (take_en) begin
      bit_q <= bit_d;
      lvl_q <= lvl_d;
      fmt_q <= fmt_d;
    end
  end
endmodule

// File: rtl/lc_line_mux.sv
module lc_line_mux
  import lc_pkg::*;
(
  input  line_fmt_e fmt,
  input  logic      bit_v,
  input  logic      lvl_v,
  input  logic      phase,
  output logic      level
);
  always_comb begin
    unique case (fmt)
      FMT_LEVEL: level = bit_v;
      FMT_XOR1:  level = lvl_v;
      FMT_RTZ:   level = bit_v & ~phase;
      FMT_MANCH: level = bit_v ^ phase;
      default:   level = 1'b0;
    endcase
  end
endmodule

// File: rtl/serial_line_coder.sv
module serial_line_coder
  import lc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [FMT_W-1:0] fmt_sel,
  output logic             line_out,
  output logic             bit_strobe
);
  logic      core_rst_n;
  logic      phase_q, phase_d, bit_start;
  logic      bit_q, bit_d, lvl_q, lvl_d;
  line_fmt_e fmt_q, fmt_d;
  logic      out_d, out_q;

  lc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  lc_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .bit_start (bit_start)
  );

  lc_bit_store u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .take_en (bit_start),
    .din     (din),
    .fmt_in  (line_fmt_e'(fmt_sel)),
    .bit_q   (bit_q),
    .bit_d   (bit_d),
    .lvl_q   (lvl_q),
    .lvl_d   (lvl_d),
    .fmt_q   (fmt_q),
    .fmt_d   (fmt_d)
  );

  // output is computed from next-cycle values, then registered
  lc_line_mux u_mux (
    .fmt   (fmt_d),
    .bit_v (bit_d),
    .lvl_v (lvl_d),
    .phase (phase_d),
    .level (out_d)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) out_q <= 1'b0;
    else             out_q <= out_d;
  end

  assign line_out   = out_q;
  assign bit_strobe = phase_q;
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst_n,
  input logic             phase_q,
  input logic [FMT_W-1:0] fmt_q,
  input logic             line_out,
  input logic             bit_strobe
);
  // R1: reset forces the outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!line_out && !bit_strobe));

  // R2: strobe alternates every cycle
  a_r2_strobe_high_low: assert property (@(posedge clk) disable iff (!core_rst_n)
    bit_strobe |=> !bit_strobe);
  a_r2_strobe_low_high: assert property (@(posedge clk) disable iff (!core_rst_n)
    !bit_strobe |=> bit_strobe);

  // R3, R4: level codes hold across the bit
  a_r3_r4_flat_bit: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase_q && (fmt_q == FMT_LEVEL || fmt_q == FMT_XOR1)) |-> $stable(line_out));

  // R5: second half of return-to-zero is low
  a_r5_rtz_low: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase_q && fmt_q == FMT_RTZ) |-> !line_out);

  // R6: Manchester always changes at mid-bit
  a_r6_manch_mid: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase_q && fmt_q == FMT_MANCH) |-> (line_out != $past(line_out)));
endmodule

bind serial_line_coder lc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .phase_q    (phase_q),
  .fmt_q      (fmt_q),
  .line_out   (line_out),
  .bit_strobe (bit_strobe)
);

// File: tb/serial_line_coder_test.sv
module serial_line_coder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       din;
  logic [1:0] fmt_sel;
  logic       line_out;
  logic       bit_strobe;

  int n_vec;
  int n_bad;
  logic lvl_m;

  serial_line_coder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .fmt_sel    (fmt_sel),
    .line_out   (line_out),
    .bit_strobe (bit_strobe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expect_lvl(input logic [1:0] f, input logic b,
                                      input logic l, input logic ph);
    case (f)
      2'b00:   return b;
      2'b01:   return l;
      2'b10:   return ph ? 1'b0 : b;
      default: return ph ? ~b : b;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic wait_strobe();
    for (int i = 0; i < 10; i++) begin
      if (bit_strobe === 1'b1) return;
      @(negedge clk);
    end
    chk("R2 strobe after release", bit_strobe, 1'b1);
  endtask

  // called at a negedge with bit_strobe high
  task automatic send_bit(input logic [1:0] f, input logic b, input string tag);
    fmt_sel = f;
    din     = b;
    lvl_m   = lvl_m ^ b;
    @(posedge clk);
    @(negedge clk);
    chk({req_of(f), " first half R9 ", tag}, line_out, expect_lvl(f, b, lvl_m, 1'b0));
    chk("R2 strobe low in first half", bit_strobe, 1'b0);
    // R7: disturb inputs mid-bit
    din     = ~b;
    fmt_sel = ~f;
    @(posedge clk);
    @(negedge clk);
    chk({req_of(f), " second half R7 ", tag}, line_out, expect_lvl(f, b, lvl_m, 1'b1));
    chk("R2 strobe high in second half", bit_strobe, 1'b1);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    lvl_m = 1'b0;
    rst_n = 1'b0;
    din = 1'b1;
    fmt_sel = 2'b11;
    repeat (4) begin
      @(negedge clk);
      chk("R1 out in reset", line_out, 1'b0);
      chk("R1 strobe in reset", bit_strobe, 1'b0);
    end
    rst_n = 1'b1;
    wait_strobe();

    // sweep every 4-bit pattern in every format
    for (int f = 0; f < 4; f++) begin
      for (int p = 0; p < 16; p++) begin
        for (int k = 3; k >= 0; k--) begin
          send_bit(2'(f), p[k], "sweep");
        end
      end
    end

    // R8: format changes on every bit, hidden level carried along
    for (int i = 0; i < 96; i++) begin
      send_bit(2'((i * 7 + i / 5) % 4), 1'((i * 13 + (i >> 2)) % 3 == 1), "R8 mix");
    end

    // mid-bit reset, then level restarts from 0
    fmt_sel = 2'b11;
    din = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async out", line_out, 1'b0);
    chk("R1 async strobe", bit_strobe, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lvl_m = 1'b0;
    wait_strobe();
    send_bit(2'b01, 1'b1, "R4 level after reset");
    send_bit(2'b01, 1'b0, "R4 hold");
    send_bit(2'b01, 1'b1, "R4 toggle back");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule